// File: doc/BRIEF.md
# Prescaled Interval Timer with Underflow Interrupt

This block is an 8-bit down-counting interval timer for a small host bus. The host starts the timer by writing a start count. The write address also selects the prescale, either one decrement per clock or one decrement every eighth clock, and it decides whether the underflow may raise the interrupt output. Reads return the running count or a status byte that holds the underflow flag. Reads have no side effects.

When the count is at zero and the next decrement is due, the count wraps to 0xFF and the underflow flag sets on that same edge. From then on the counter decrements on every clock, whatever prescale was chosen. The flag stays set until the host writes the timer again. The interrupt output is the flag gated by the enable that was captured with the last timer write.

Top module: `iv_timer`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first clock after it, the count is 0, the flag is clear, `irq` is 0, the prescale is divide-by-1 and the interrupt is disabled.
- R2: A write (`wr_en`=1) is a timer load only when addr[4]=1, addr[2]=1 and addr[1]=0. In a load, addr[0]=1 selects divide-by-8 and addr[0]=0 selects divide-by-1, and addr[3]=1 enables the interrupt. A write to any other address changes nothing.
- R3: With divide-by-1, the count decrements by one on every clock after the load edge.
- R4: With divide-by-8, the count holds for seven clocks after the load edge and decrements on the eighth. The eighth-clock phase restarts on every load.
- R5: When a decrement falls due while the count is 0, the count becomes 0xFF and the flag sets on that same edge. When the count first reaches 0, the flag does not set.
- R6: While the flag is set, the count decrements on every clock, whatever the prescale.
- R7: `rd_data` is selected by addr[2:0] alone. The value 4 returns the count. The value 5 returns the status byte, with the flag in bit 7 and the other bits 0. Every other value returns 0. Reading has no effect on any state.
- R8: `irq` is 1 exactly when the flag is set and the last load enabled the interrupt.
- R9: A timer load clears the flag and `irq` on its edge and sets the count to the written value.
- R10: A load on the same edge on which an underflow would occur takes priority. No flag sets, and the written count is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 5 | Register address for reads and writes |
| wr_data | input | 8 | Start count for a timer load |
| rd_data | output | 8 | Count or status, selected by addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a load that lands exactly on the edge where a zero count would underflow. The stimulus reaches it with two loads in a row: a count of 1 at divide-by-1, then a second load timed to arrive one clock after the count reaches zero. A divide-by-8 load of zero also matters, because it shows the change from the slow cadence to decrementing on every clock. A reload in the middle of a prescale period shows that the phase restarts. A behavioural model in the bench follows every cycle, including random writes to decoded and undecoded addresses.

// File: rtl/iv_timer_pkg.sv
package iv_timer_pkg;

  localparam int ADDR_BITS = 5;
  localparam int RD_COUNT  = 4;
  localparam int RD_STATUS = 5;

  typedef struct packed {
    logic hit;
    logic slow;
    logic irq_en;
  } wr_dec_t;

  // Timer load: a4=1, a2=1, a1=0; a0 picks the slow prescale, a3 the irq enable.
  function automatic wr_dec_t decode_wr(input logic [ADDR_BITS-1:0] a);
    wr_dec_t d;
    d.hit    = a[4] & a[2] & ~a[1];
    d.slow   = a[0];
    d.irq_en = a[3];
    return d;
  endfunction

  // Count step with borrow out: borrow is set when stepping from zero.
  function automatic logic [8:0] step_down(input logic [7:0] c);
    return {(c == 8'd0), c - 8'd1};
  endfunction

  function automatic logic [7:0] read_mux(input logic [2:0] sel,
                                          input logic [7:0] cnt,
                                          input logic       flg);
    case (sel)
      3'(RD_COUNT):  return cnt;
      3'(RD_STATUS): return {flg, 7'd0};
      default:       return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/iv_prescaler.sv
module iv_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic slow_tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign slow_tick = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] phase;
      assign slow_tick = (phase == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || restart)  phase <= '0;
        else if (slow_tick)  phase <= '0;
        else                 phase <= phase + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/iv_downcount.sv
module iv_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         flag,
  output logic         underflow
);
  import iv_timer_pkg::*;

  logic [8:0] step;
  assign step      = step_down(count);
  assign underflow = tick & ~load & step[8];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (load) begin
      count <= load_val;
      flag  <= 1'b0;
    end else if (tick) begin
      count <= step[W-1:0];
      if (underflow) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/iv_timer.sv
module iv_timer #(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [iv_timer_pkg::ADDR_BITS-1:0]  addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                irq
);
  import iv_timer_pkg::*;

  wr_dec_t     dec;
  logic        load;
  logic        slow_q;
  logic        en_q;
  logic        slow_tick;
  logic        tick;
  logic        flag;
  logic        underflow;
  logic [DATA_W-1:0] count;

  assign dec  = decode_wr(addr);
  assign load = wr_en & dec.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (load) begin
      slow_q <= dec.slow;
      en_q   <= dec.irq_en;
    end
  end

  iv_prescaler #(.DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(load), .slow_tick(slow_tick)
  );

  // After underflow the counter runs every clock regardless of prescale.
  assign tick = flag | ~slow_q | slow_tick;

  iv_downcount #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .tick(tick),
    .count(count), .flag(flag), .underflow(underflow)
  );

  assign rd_data = read_mux(addr[2:0], count, flag);
  assign irq     = flag & en_q;
endmodule

// File: rtl/iv_timer_chk.sv
module iv_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              tick,
  input logic              slow_q,
  input logic              underflow,
  input logic              flag,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] wr_data
);
  p_load_clears_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (!flag && !irq));

  p_load_takes_value_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(wr_data)));

  p_underflow_wraps_r5: assert property (@(posedge clk) disable iff (rst)
    underflow |=> (flag && count == {DATA_W{1'b1}}));

  p_free_run_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !load) |=> (count == DATA_W'($past(count) - 1'b1)));

  p_fast_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !slow_q) |=> (count == DATA_W'($past(count) - 1'b1)));

  p_slow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(count));

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

bind iv_timer iv_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .tick(tick), .slow_q(slow_q),
  .underflow(underflow), .flag(flag), .irq(irq), .count(count),
  .wr_data(wr_data)
);

// File: tb/iv_timer_bench.sv
`timescale 1ns/1ps
module iv_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] addr = 5'd4;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  int m_cnt = 0, m_pre = 0, m_slow = 0, m_flag = 0, m_en = 0;

  always #2 clk = ~clk;

  iv_timer u_iv_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic int exp_read(input int sel);
    if (sel == 4) return m_cnt;
    if (sel == 5) return m_flag * 128;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit due;
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_slow = 0; m_flag = 0; m_en = 0;
    end else if (wr_en && addr[4] && addr[2] && !addr[1]) begin
      m_cnt = wr_data; m_pre = 0; m_slow = addr[0]; m_en = addr[3]; m_flag = 0;
    end else begin
      due = (m_flag != 0) || (m_slow == 0) || (m_pre == 7);
      m_pre = (m_pre + 1) % 8;
      if (due) begin
        if (m_cnt == 0) begin m_cnt = 255; m_flag = 1; end
        else m_cnt = m_cnt - 1;
      end
    end
    #1;
    vectors++;
    if (int'(rd_data) != exp_read(addr % 8)) begin
      miscompares++;
      $display("FAIL %s rd_data addr=%0h actual=%0h expected=%0h", tag, addr, rd_data, exp_read(addr % 8));
    end
    vectors++;
    if (int'(irq) != (m_flag & m_en)) begin
      miscompares++;
      $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, m_flag & m_en);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [4:0] a);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tag = "R1"; rst = 1'b1; idle(3, 5'd4);
    @(negedge clk); rst = 1'b0; idle(1, 5'd5);
    tag = "R3"; wr(5'h14, 8'd128); idle(6, 5'd4);
    tag = "R4"; wr(5'h15, 8'd28); idle(10, 5'd4);
    wr(5'h15, 8'd28); idle(3, 5'd4); wr(5'h15, 8'd40); idle(12, 5'd4);
    tag = "R5"; wr(5'h1C, 8'd1); idle(4, 5'd5);
    tag = "R9"; wr(5'h1C, 8'd1); idle(1, 5'd5);
    tag = "R6"; wr(5'h15, 8'd0); idle(16, 5'd4);
    wr(5'h15, 8'd2); idle(30, 5'd4);
    tag = "R8"; wr(5'h14, 8'd1); idle(5, 5'd5);
    wr(5'h1D, 8'd0); idle(12, 5'd5);
    tag = "R2"; wr(5'h14, 8'd200); idle(2, 5'd4);
    wr(5'h04, 8'h33); wr(5'h16, 8'h44); wr(5'h00, 8'h55);
    wr(5'h0C, 8'h66); wr(5'h1E, 8'h77); idle(3, 5'd4);
    tag = "R7";
    for (int i = 0; i < 32; i++) idle(1, 5'(i));
    tag = "R10"; wr(5'h1C, 8'd1); wr(5'h1C, 8'd5); idle(8, 5'd5);
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 6) == 0;
      addr = 5'($urandom);
      wr_data = 8'($urandom % 20);
    end
    @(negedge clk); wr_en = 1'b0;
    idle(20, 5'd4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule